// File: doc/BRIEF.md
# Prescaled Match Timer Counter

This block is a free-running count engine for timing and waveform generation. A prescaler divides the clock by a programmable ratio, and each time it completes a period the main count moves up by one. Four match values are compared against the main count all the time. When the count first takes on a match value, that channel can raise an interrupt flag, fold the count back to zero at the end of that count period, or halt the whole engine. Each channel also owns a match output pin whose reaction to a match is chosen from four actions.

Software reaches the block through a flat register port with a combinational read path. It sets the enable and a separate synchronous counter clear, loads the prescale ratio and the four match values, picks the per-channel actions, and reads back both counters, the pending flags and the state of the match pins. Flags stay set until software writes a one to them. The interrupt output is high while any flag is set.

Register map (4-bit address): 0 control (bit 0 enable, bit 1 counter clear), 1 prescale ratio, 2 match actions, 3 pin actions and pin states, 4 interrupt flags, 5 main count (read only), 6 prescale count (read only), 8 to 11 match values for channels 0 to 3.

Top module: `match_timer`

## Requirements
- R1: While enabled, the prescale count steps up by one each clock. On a clock where the prescale count is at or above the prescale ratio (address 1), it returns to 0 and the main count steps up by one. A ratio of 0 moves the main count every clock, and a ratio of 3 moves it every 4 clocks.
- R2: While the enable (address 0 bit 0) is 0, both counts hold their values.
- R3: While the counter clear (address 0 bit 1) is set, both counts are forced to 0 on every clock, whatever the enable.
- R4: For channel m, match-action bit 3m+1 set at address 2 makes the main count go to 0 in place of m's match value plus one, at the end of the prescale period in which it held that value. With a ratio of 2 and a match value of 6, the main count runs 5, 6, 0, 1 and holds each value for 3 clocks.
- R5: For channel m, match-action bit 3m set at address 2 sets flag bit m (address 4) one clock after the main count enters that channel's match value. The interrupt output is high exactly while any flag bit is set. With bit 3m clear, a match sets no flag.
- R6: Writing a 1 to a flag bit clears it. Writing a 0 leaves it unchanged.
- R7: For channel m, match-action bit 3m+2 set makes the enable fall one clock after the main count enters the match value. On that clock neither count advances, so both stay frozen at their values from the match.
- R8: Pin m's action lies in bits 2m+1:2m of address 3: 00 leaves it alone, 01 drives it low, 10 drives it high, 11 toggles it. The action takes effect one clock after the count enters the match value. Bits 11:8 of address 3 give the pin states on read and load them on write. All pins reset to 0.
- R9: Match actions fire once for each entry into a match value. They do not fire again while the count stays on that value through a prescale period.
- R10: After reset every register, both counts, the flags, the interrupt output and the match pins read 0.
- R11: The prescale ratio and the match values read back all 32 bits as written. The match-action field reads back only its low 12 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational on regAddr |
| irq | output | 1 | High while any match flag is set |
| running | output | 1 | Current enable state |
| matchOut | output | 4 | Match output pins, one per channel |

## Verification
An incorrect prescale phase shows up in the count read from address 5 within one prescale period. The directed runs compare that count every clock against a model built from the requirements, so a wrong fold-back value or a period that is off by one clock shows at the first clock where it differs. A broken entry detector either fires again or never fires, and that shows at the match pins or the interrupt output on the clock after entry, while the count still holds its match value. A missed stop shows as the enable still reading high one clock after entry, with the count moving on.

// File: rtl/mt_pkg.sv
package mt_pkg;

  // Register addresses
  localparam int ADDR_CTRL     = 0;
  localparam int ADDR_PRESCALE = 1;
  localparam int ADDR_MACT     = 2;
  localparam int ADDR_PINS     = 3;
  localparam int ADDR_FLAGS    = 4;
  localparam int ADDR_COUNT    = 5;
  localparam int ADDR_PCOUNT   = 6;
  localparam int ADDR_MATCH0   = 8;

  // Pin action codes
  localparam logic [1:0] PIN_KEEP   = 2'b00;
  localparam logic [1:0] PIN_LOW    = 2'b01;
  localparam logic [1:0] PIN_HIGH   = 2'b10;
  localparam logic [1:0] PIN_TOGGLE = 2'b11;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;    // force both counts to zero
    logic advance;  // counting allowed this cycle
    logic wrap;     // a reset-on-match channel holds the current count
  } mtStrobe_t;

endpackage

// File: rtl/mt_datapath.sv
module mt_datapath
  import mt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mtStrobe_t        strobe,
  input  logic [CNT_W-1:0] prescale,
  output logic [CNT_W-1:0] pcount,
  output logic [CNT_W-1:0] tcount
);

  logic tickNow;
  assign tickNow = (pcount >= prescale);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcount <= '0;
      tcount <= '0;
    end else if (strobe.clear) begin
      pcount <= '0;
      tcount <= '0;
    end else if (strobe.advance) begin
      if (tickNow) begin
        pcount <= '0;
        tcount <= strobe.wrap ? '0 : tcount + 1'b1;
      end else begin
        pcount <= pcount + 1'b1;
      end
    end
  end

  // R3: clear forces both counts to zero
  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (pcount == '0 && tcount == '0));

  // R2: no advance, no clear -> counts hold
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && !strobe.advance) |=> ($stable(pcount) && $stable(tcount)));

  // R1: prescale count steps by one inside a period
  a_r1_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.clear && !tickNow) |=>
      (pcount == $past(pcount) + 1'b1 && $stable(tcount)));

  // R4: end of period with reset-on-match folds the count to zero
  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.clear && tickNow && strobe.wrap) |=> (tcount == '0));

endmodule

// File: rtl/mt_ctrl.sv
module mt_ctrl
  import mt_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 4,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  output logic [CNT_W-1:0]  regRdata,
  input  logic [CNT_W-1:0]  pcount,
  input  logic [CNT_W-1:0]  tcount,
  output logic [CNT_W-1:0]  prescale,
  output mtStrobe_t         strobe,
  output logic              irq,
  output logic              running,
  output logic [NUM_MATCH-1:0] matchOut
);

  localparam int ACT_W = 3 * NUM_MATCH;
  localparam int PIN_W = 2 * NUM_MATCH;

  logic                 enReg, clrReg;
  logic [CNT_W-1:0]     prescaleReg;
  logic [CNT_W-1:0]     matchReg [NUM_MATCH];
  logic [ACT_W-1:0]     matchAct;
  logic [PIN_W-1:0]     pinAct;
  logic [NUM_MATCH-1:0] pinState, pinNext;
  logic [NUM_MATCH-1:0] flags;
  logic [NUM_MATCH-1:0] seen;

  logic [NUM_MATCH-1:0] hit, evt, intEn, rstEn, stopEn;
  logic                 stopNow;

  logic ctrlWr, preWr, actWr, pinWr, flagWr;
  assign ctrlWr = regWe && (regAddr == ADDR_W'(ADDR_CTRL));
  assign preWr  = regWe && (regAddr == ADDR_W'(ADDR_PRESCALE));
  assign actWr  = regWe && (regAddr == ADDR_W'(ADDR_MACT));
  assign pinWr  = regWe && (regAddr == ADDR_W'(ADDR_PINS));
  assign flagWr = regWe && (regAddr == ADDR_W'(ADDR_FLAGS));

  // Per-channel compare and action bits
  for (genvar g = 0; g < NUM_MATCH; g++) begin : g_chan
    assign intEn[g]  = matchAct[3*g];
    assign rstEn[g]  = matchAct[3*g+1];
    assign stopEn[g] = matchAct[3*g+2];
    assign hit[g]    = (tcount == matchReg[g]);
    assign evt[g]    = enReg && hit[g] && !seen[g];
  end

  assign stopNow        = |(evt & stopEn);
  assign strobe.clear   = clrReg;
  assign strobe.advance = enReg && !stopNow;
  assign strobe.wrap    = |(hit & rstEn);

  // Next pin state: software load first, then match actions
  always_comb begin
    pinNext = pinWr ? regWdata[ACT_W-1:PIN_W] : pinState;
    for (int m = 0; m < NUM_MATCH; m++) begin
      if (evt[m]) begin
        case (pinAct[2*m +: 2])
          PIN_LOW:    pinNext[m] = 1'b0;
          PIN_HIGH:   pinNext[m] = 1'b1;
          PIN_TOGGLE: pinNext[m] = ~pinNext[m];
          default:    pinNext[m] = pinNext[m];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg       <= 1'b0;
      clrReg      <= 1'b0;
      prescaleReg <= '0;
      matchAct    <= '0;
      pinAct      <= '0;
      pinState    <= '0;
      flags       <= '0;
      seen        <= '0;
      for (int m = 0; m < NUM_MATCH; m++) matchReg[m] <= '0;
    end else begin
      if (ctrlWr) begin
        enReg  <= regWdata[0];
        clrReg <= regWdata[1];
      end else if (stopNow) begin
        enReg <= 1'b0;
      end
      if (preWr) prescaleReg <= regWdata;
      if (actWr) matchAct <= regWdata[ACT_W-1:0];
      if (pinWr) pinAct <= regWdata[PIN_W-1:0];
      for (int m = 0; m < NUM_MATCH; m++) begin
        if (regWe && regAddr == ADDR_W'(ADDR_MATCH0 + m)) matchReg[m] <= regWdata;
      end
      pinState <= pinNext;
      flags    <= (flagWr ? (flags & ~regWdata[NUM_MATCH-1:0]) : flags) | (evt & intEn);
      seen     <= hit & (seen | evt);
    end
  end

  // Combinational read path
  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(ADDR_CTRL))          regRdata = CNT_W'({clrReg, enReg});
    else if (regAddr == ADDR_W'(ADDR_PRESCALE)) regRdata = prescaleReg;
    else if (regAddr == ADDR_W'(ADDR_MACT))     regRdata = CNT_W'(matchAct);
    else if (regAddr == ADDR_W'(ADDR_PINS))     regRdata = CNT_W'({pinState, pinAct});
    else if (regAddr == ADDR_W'(ADDR_FLAGS))    regRdata = CNT_W'(flags);
    else if (regAddr == ADDR_W'(ADDR_COUNT))    regRdata = tcount;
    else if (regAddr == ADDR_W'(ADDR_PCOUNT))   regRdata = pcount;
    else begin
      for (int m = 0; m < NUM_MATCH; m++) begin
        if (regAddr == ADDR_W'(ADDR_MATCH0 + m)) regRdata = matchReg[m];
      end
    end
  end

  assign prescale = prescaleReg;
  assign irq      = |flags;
  assign running  = enReg;
  assign matchOut = pinState;

  // R5: an enabled interrupt match raises irq on the next clock
  a_r5_irq_follows: assert property (@(posedge clk) disable iff (!rstN)
    (|(evt & intEn)) |=> irq);

  // R6: a pending interrupt stays until software clears it
  a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !flagWr) |=> irq);

  // R7: stop-on-match drops the enable on the next clock
  a_r7_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    (stopNow && !ctrlWr) |=> !running);

  // R9: no channel fires on two consecutive clocks
  a_r9_single_fire: assert property (@(posedge clk) disable iff (!rstN)
    (|evt) |=> ((evt & $past(evt)) == '0));

endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 4,
  parameter int ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [CNT_W-1:0]     regWdata,
  output logic [CNT_W-1:0]     regRdata,
  output logic                 irq,
  output logic                 running,
  output logic [NUM_MATCH-1:0] matchOut
);

  mtStrobe_t        strobe;
  logic [CNT_W-1:0] prescale, pcount, tcount;

  mt_ctrl #(
    .CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .pcount(pcount), .tcount(tcount), .prescale(prescale), .strobe(strobe),
    .irq(irq), .running(running), .matchOut(matchOut)
  );

  mt_datapath #(
    .CNT_W(CNT_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .prescale(prescale),
    .pcount(pcount), .tcount(tcount)
  );

endmodule

// File: tb/match_timer_bench.sv
`timescale 1ns/1ps
module match_timer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irq, running;
  logic [3:0]  matchOut;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  match_timer u_match_timer (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq),
    .running(running), .matchOut(matchOut)
  );

  localparam logic [3:0] A_CTRL = 4'd0, A_PRE = 4'd1, A_MACT = 4'd2, A_PINS = 4'd3,
                         A_FLAGS = 4'd4, A_CNT = 4'd5, A_PCNT = 4'd6, A_M0 = 4'd8;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R10, R11: reset state and readback
  task automatic t_reset_readback();
    logic [31:0] d;
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), d);
      chk("R10 reset register value", d, 32'h0);
    end
    chk("R10 reset irq", {31'b0, irq}, 32'h0);
    chk("R10 reset pins", {28'b0, matchOut}, 32'h0);
    wr(A_PRE, 32'h1234_5678);
    rd(A_PRE, d);  chk("R11 prescale readback", d, 32'h1234_5678);
    wr(A_M0 + 4'd3, 32'hCAFE_0003);
    rd(A_M0 + 4'd3, d); chk("R11 match3 readback", d, 32'hCAFE_0003);
    wr(A_MACT, 32'hFFFF_FFFF);
    rd(A_MACT, d); chk("R11 match action width", d, 32'h0000_0FFF);
    wr(A_MACT, 32'h0);
  endtask

  // R1, R2, R3: prescale, hold when disabled, clear
  task automatic t_prescale_hold_clear();
    logic [31:0] d;
    wr(A_PRE, 32'd3);
    wr(A_CTRL, 32'h1);
    wait_clk(9);
    rd(A_CNT, d);  chk("R1 count after 9 clocks ratio 3", d, 32'd2);
    rd(A_PCNT, d); chk("R1 prescale count after 9 clocks", d, 32'd1);
    wr(A_CTRL, 32'h0);
    wait_clk(5);
    rd(A_CNT, d);  chk("R2 count held while disabled", d, 32'd2);
    rd(A_PCNT, d); chk("R2 prescale count held while disabled", d, 32'd2);
    wr(A_CTRL, 32'h2);
    wait_clk(1);
    rd(A_CNT, d);  chk("R3 clear zeroes count", d, 32'd0);
    rd(A_PCNT, d); chk("R3 clear zeroes prescale count", d, 32'd0);
    wr(A_CTRL, 32'h3);
    wait_clk(4);
    rd(A_CNT, d);  chk("R3 clear wins over enable", d, 32'd0);
    wr(A_CTRL, 32'h0);
  endtask

  // R4, R5, R6: reset on match with interrupt, flag clearing
  task automatic t_reset_on_match();
    logic [31:0] d;
    int ePc, eTc;
    wr(A_PRE, 32'd2);
    wr(A_M0, 32'd6);
    wr(A_MACT, 32'h3);
    wr(A_CTRL, 32'h2);
    wr(A_CTRL, 32'h1);
    ePc = 0; eTc = 0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (ePc >= 2) begin ePc = 0; eTc = (eTc == 6) ? 0 : eTc + 1; end
      else ePc++;
      rd(A_CNT, d);
      chk("R4 count sequence with fold-back at 6", d, 32'(eTc));
      if (i == 18) chk("R5 irq low on entry clock", {31'b0, irq}, 32'h0);
      if (i == 19) chk("R5 irq one clock after entry", {31'b0, irq}, 32'h1);
    end
    wr(A_CTRL, 32'h0);
    rd(A_FLAGS, d); chk("R5 flag bit 0 set", d, 32'h1);
    wr(A_FLAGS, 32'h0);
    rd(A_FLAGS, d); chk("R6 writing 0 keeps flag", d, 32'h1);
    wr(A_FLAGS, 32'h1);
    rd(A_FLAGS, d); chk("R6 writing 1 clears flag", d, 32'h0);
    chk("R6 irq low after clear", {31'b0, irq}, 32'h0);
  endtask

  // R7: stop on match for channel 1
  task automatic t_stop_on_match();
    logic [31:0] d;
    wr(A_MACT, 32'h28);
    wr(A_M0 + 4'd1, 32'd5);
    wr(A_CTRL, 32'h2);
    wr(A_CTRL, 32'h1);
    wait_clk(15);
    chk("R7 still running on entry clock", {31'b0, running}, 32'h1);
    rd(A_CNT, d); chk("R7 count at match value", d, 32'd5);
    wait_clk(1);
    chk("R7 enable cleared one clock after entry", {31'b0, running}, 32'h0);
    rd(A_FLAGS, d); chk("R5 flag bit 1 on stop channel", d, 32'h2);
    wait_clk(6);
    rd(A_CNT, d);  chk("R7 count frozen", d, 32'd5);
    rd(A_PCNT, d); chk("R7 prescale count frozen", d, 32'd0);
    wr(A_FLAGS, 32'hF);
  endtask

  // R8, R9: pin actions and once-per-entry firing
  task automatic t_pin_actions();
    logic [31:0] d;
    wr(A_PRE, 32'd3);
    wr(A_MACT, 32'h0);
    for (int m = 0; m < 4; m++) wr(A_M0 + 4'(m), 32'd2);
    wr(A_PINS, 32'h0000_0C1B);  // pin0 toggle, pin1 high, pin2 low, pin3 keep; pins 2,3 preset
    wr(A_CTRL, 32'h2);
    wr(A_CTRL, 32'h1);
    wait_clk(8);
    chk("R8 pins unchanged on entry clock", {28'b0, matchOut}, 32'h0000_000C);
    wait_clk(1);
    chk("R8 pin actions one clock after entry", {28'b0, matchOut}, 32'h0000_000B);
    wait_clk(2);
    chk("R9 toggle fired once while count holds", {28'b0, matchOut}, 32'h0000_000B);
    wait_clk(1);
    rd(A_CNT, d); chk("R9 count moved past match", d, 32'd3);
    chk("R5 no irq with interrupt bits clear", {31'b0, irq}, 32'h0);
    rd(A_PINS, d); chk("R8 pin state readback", d, 32'h0000_0B1B);
    wr(A_CTRL, 32'h0);
  endtask

  // R1: ratio 0 counts every clock
  task automatic t_ratio_zero();
    logic [31:0] d;
    wr(A_PRE, 32'd0);
    wr(A_CTRL, 32'h2);
    wr(A_CTRL, 32'h1);
    wait_clk(7);
    rd(A_CNT, d);  chk("R1 ratio 0 count after 7 clocks", d, 32'd7);
    rd(A_PCNT, d); chk("R1 ratio 0 prescale count stays 0", d, 32'd0);
    wr(A_CTRL, 32'h0);
  endtask

  initial begin
    wait_clk(3);
    rstN = 1'b1;
    wait_clk(1);
    t_reset_readback();
    t_prescale_hold_clear();
    t_reset_on_match();
    t_stop_on_match();
    t_pin_actions();
    t_ratio_zero();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule